// File: doc/BRIEF.md
# Serial Programming Command Frame Receiver

This block takes the 16-bit words delivered by a serial shift interface running in word mode and splits them into command frames. The first word of every frame is a header. Its upper four bits name the command and its lower twelve bits give the frame size in words. The receiver checks the command against a parameter mask of supported commands. For a supported command it forwards each following word unchanged, with a valid strobe. For any other command it raises a single negative-acknowledge pulse and swallows the rest of the frame. The size field alone decides where the frame ends. Payload contents are never inspected.

Each frame ends with a one-cycle done pulse. A programmable quiet interval then follows, during which a new command must not start. The default interval is 25 ms at a 40 MHz clock. A word that arrives inside that interval is thrown away and sets a sticky error flag. A busy output covers both frame reception and the quiet interval, so the upstream side can pace itself.

Top module: `cmd_frame_rx`

## Requirements
- R1: One cycle after a header word is accepted, `opcode_out` shows header bits 15:12 and `length_out` shows header bits 11:0. Both hold until the next header is accepted.
- R2: For an opcode whose bit is set in `SUPPORT_MASK`, each of the next length-1 accepted words appears unchanged on `payload_out`, with `payload_valid` high for exactly one cycle, one cycle after that word.
- R3: A length of 0 or 1 makes the frame header-only. `frame_done` pulses one cycle after the header, and no payload strobe follows.
- R4: `frame_done` is a one-cycle pulse. For a frame that has words after the header, it falls in the same cycle as the output of the final word.
- R5: For an opcode whose mask bit is clear, `nack_valid` pulses once, one cycle after the header. The next length-1 words are consumed without any `payload_valid`, and `frame_done` follows the last of them.
- R6: If `frame_done` is high in cycle T, a header presented in cycle T+GAP_CYCLES is accepted normally.
- R7: A word presented in cycles T through T+GAP_CYCLES-1 is dropped: it changes neither `opcode_out` nor the strobes. It sets `gap_error` in the following cycle, and `gap_error` then stays high until reset.
- R8: `busy` rises the cycle after a header is accepted and stays high through cycle T+GAP_CYCLES-1. It is low in cycle T+GAP_CYCLES and whenever the receiver is idle.
- R9: Cycles with `word_valid` low inside a frame pause it. They produce no payload strobe and no frame end, and they do not count toward the length.
- R10: While `rst_n` is sampled low, every output returns to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| word_in | input | 16 | Word from the serial shift interface |
| word_valid | input | 1 | `word_in` carries a new word this cycle |
| opcode_out | output | 4 | Command field of the last accepted header |
| length_out | output | 12 | Word-count field of the last accepted header |
| payload_out | output | 16 | Forwarded payload word |
| payload_valid | output | 1 | `payload_out` is new this cycle |
| frame_done | output | 1 | One-cycle pulse at the end of each frame |
| nack_valid | output | 1 | One-cycle pulse for an unsupported command |
| gap_error | output | 1 | Sticky flag: a word arrived during the quiet interval |
| busy | output | 1 | Frame in progress or quiet interval running |

## Verification
The bench builds the receiver with `GAP_CYCLES` of 4 and a mask of 16'hA5C3, which mixes supported and unsupported codes. With this build, every one of the sixteen opcodes can be swept against lengths 0, 1, 2, 3 and 6, with and without idle bubbles between payload words. The short interval lets every frame be followed by a header at the earliest legal cycle, and it places a deliberate intrusion in the last forbidden cycle. A longer frame and a reset at the end cover the sticky flag and its clearing.

// File: rtl/cfr_pkg.sv
// Shared types for the command frame receiver.
// Assumes: nothing beyond IEEE 1800-2017.
package cfr_pkg;
    // Receiver phases: waiting for a header, forwarding payload,
    // discarding an unsupported frame, enforcing the quiet interval.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_DROP = 2'd2,
        ST_GAP  = 2'd3
    } cfr_state_e;
endpackage

// File: rtl/cfr_hdr_decode.sv
// Header decoder: splits a header word into command and size fields,
// looks the command up in the support mask and derives the number of
// words that still follow the header.
// Assumes: the size field counts the header itself, so 0 and 1 both
// mean a header-only frame.
module cfr_hdr_decode #(
    parameter int OPC_W = 4,
    parameter int LEN_W = 12,
    parameter logic [(1<<OPC_W)-1:0] SUPPORT_MASK = '1,
    localparam int WORD_W = OPC_W + LEN_W
) (
    input  logic [WORD_W-1:0] hdr,
    output logic [OPC_W-1:0]  opc,
    output logic [LEN_W-1:0]  len,
    output logic              supported,
    output logic              hdr_only,
    output logic [LEN_W-1:0]  tail_cnt
);
    // Field split, mask lookup and tail size.
    always_comb begin
        opc       = hdr[WORD_W-1 -: OPC_W];
        len       = hdr[LEN_W-1:0];
        supported = SUPPORT_MASK[opc];
        hdr_only  = (len <= LEN_W'(1));
        tail_cnt  = len - LEN_W'(1);
    end
endmodule

// File: rtl/cfr_word_ctr.sv
// Remaining-word counter for the body of a frame.
// Assumes: load is asserted only with a nonzero load value, and step is
// asserted only while a frame body is open.
module cfr_word_ctr #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             step,
    output logic             last
);
    logic [LEN_W-1:0] remaining;

    // Load on a header, count down on each body word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remaining <= '0;
        else if (load)
            remaining <= load_val;
        else if (step)
            remaining <= remaining - LEN_W'(1);
    end

    // The word being taken now closes the frame.
    always_comb last = (remaining == LEN_W'(1));
endmodule

// File: rtl/cfr_gap_timer.sv
// Quiet-interval timer: after start it reports at_end in the
// GAP_CYCLES-th cycle, counting the start cycle's successor as the first.
// Assumes: GAP_CYCLES >= 1; run is held while the interval is active.
module cfr_gap_timer #(
    parameter int GAP_CYCLES = 1_000_000,
    localparam int GAP_W = (GAP_CYCLES < 2) ? 1 : $clog2(GAP_CYCLES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic at_end
);
    localparam logic [GAP_W-1:0] RELOAD = GAP_W'(GAP_CYCLES - 1);

    logic [GAP_W-1:0] cnt;

    // Reload on frame end, count down while the interval runs.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= RELOAD;
        else if (run && cnt != '0)
            cnt <= cnt - GAP_W'(1);
    end

    // Final cycle of the interval.
    always_comb at_end = (cnt == '0);
endmodule

// File: rtl/cmd_frame_rx.sv
// Command frame receiver top. It accepts a header, forwards or discards
// the words that follow it, pulses done at the end of each frame, and
// holds off the next header for GAP_CYCLES cycles.
// Assumes: words arrive already assembled; the size field is trusted.
// There is no resynchronisation after a wrong size.
module cmd_frame_rx #(
    parameter int OPC_W = 4,
    parameter int LEN_W = 12,
    parameter logic [(1<<OPC_W)-1:0] SUPPORT_MASK = 16'hFFFF,
    parameter int GAP_CYCLES = 1_000_000,
    localparam int WORD_W = OPC_W + LEN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_in,
    input  logic              word_valid,
    output logic [OPC_W-1:0]  opcode_out,
    output logic [LEN_W-1:0]  length_out,
    output logic [WORD_W-1:0] payload_out,
    output logic              payload_valid,
    output logic              frame_done,
    output logic              nack_valid,
    output logic              gap_error,
    output logic              busy
);
    import cfr_pkg::*;

    cfr_state_e       state;
    logic [OPC_W-1:0] dec_opc;
    logic [LEN_W-1:0] dec_len;
    logic [LEN_W-1:0] dec_tail;
    logic             dec_ok;
    logic             dec_short;
    logic             ctr_last;
    logic             gap_end;
    logic             take_hdr;
    logic             take_body;
    logic             frame_end;

    cfr_hdr_decode #(
        .OPC_W(OPC_W), .LEN_W(LEN_W), .SUPPORT_MASK(SUPPORT_MASK)
    ) u_dec (
        .hdr(word_in), .opc(dec_opc), .len(dec_len),
        .supported(dec_ok), .hdr_only(dec_short), .tail_cnt(dec_tail)
    );

    // Event decode for the counter and the timer.
    always_comb begin
        take_hdr  = (state == ST_IDLE) && word_valid;
        take_body = ((state == ST_RECV) || (state == ST_DROP)) && word_valid;
        frame_end = (take_hdr && dec_short) || (take_body && ctr_last);
    end

    cfr_word_ctr #(.LEN_W(LEN_W)) u_ctr (
        .clk(clk), .rst_n(rst_n),
        .load(take_hdr && !dec_short), .load_val(dec_tail),
        .step(take_body), .last(ctr_last)
    );

    cfr_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk(clk), .rst_n(rst_n),
        .start(frame_end), .run(state == ST_GAP), .at_end(gap_end)
    );

    // Phase sequencing and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            opcode_out    <= '0;
            length_out    <= '0;
            payload_out   <= '0;
            payload_valid <= 1'b0;
            frame_done    <= 1'b0;
            nack_valid    <= 1'b0;
            gap_error     <= 1'b0;
        end else begin
            payload_valid <= 1'b0;
            frame_done    <= 1'b0;
            nack_valid    <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (word_valid) begin
                        opcode_out <= dec_opc;
                        length_out <= dec_len;
                        nack_valid <= !dec_ok;
                        if (dec_short) begin
                            frame_done <= 1'b1;
                            state      <= ST_GAP;
                        end else begin
                            state <= dec_ok ? ST_RECV : ST_DROP;
                        end
                    end
                end
                ST_RECV, ST_DROP: begin
                    if (word_valid) begin
                        if (state == ST_RECV) begin
                            payload_out   <= word_in;
                            payload_valid <= 1'b1;
                        end
                        if (ctr_last) begin
                            frame_done <= 1'b1;
                            state      <= ST_GAP;
                        end
                    end
                end
                ST_GAP: begin
                    if (word_valid)
                        gap_error <= 1'b1;
                    if (gap_end)
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Busy covers every phase except waiting for a header.
    always_comb busy = (state != ST_IDLE);
endmodule

// File: rtl/cfr_checker.sv
// Property checker for cmd_frame_rx, attached with bind.
// Assumes: the same SUPPORT_MASK as the instance it observes.
module cfr_checker #(
    parameter int OPC_W = 4,
    parameter logic [(1<<OPC_W)-1:0] SUPPORT_MASK = '1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             word_valid,
    input logic [OPC_W-1:0] opcode_out,
    input logic             payload_valid,
    input logic             frame_done,
    input logic             nack_valid,
    input logic             gap_error,
    input logic             busy
);
    // R2: payload strobes only for supported commands and only after an input word.
    a_r2_payload_supported: assert property (@(posedge clk) disable iff (!rst_n)
        payload_valid |-> (SUPPORT_MASK[opcode_out] && $past(word_valid)));

    // R5: a negative acknowledge names an unsupported command.
    a_r5_nack_unsupported: assert property (@(posedge clk) disable iff (!rst_n)
        nack_valid |-> (!SUPPORT_MASK[opcode_out] && $past(word_valid)));

    // R5: a negative acknowledge and a payload strobe never coincide.
    a_r5_nack_no_payload: assert property (@(posedge clk) disable iff (!rst_n)
        !(nack_valid && payload_valid));

    // R4: done is a single-cycle pulse.
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R8: busy covers the done cycle and every payload strobe.
    a_r8_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done || payload_valid) |-> busy);

    // R7: the intrusion flag is sticky.
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        gap_error |=> gap_error);
endmodule

bind cmd_frame_rx cfr_checker #(
    .OPC_W(OPC_W), .SUPPORT_MASK(SUPPORT_MASK)
) u_cfr_checker (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid),
    .opcode_out(opcode_out), .payload_valid(payload_valid),
    .frame_done(frame_done), .nack_valid(nack_valid),
    .gap_error(gap_error), .busy(busy)
);

// File: tb/cmd_frame_rx_test.sv
// Bench for cmd_frame_rx: sweeps all opcodes against several lengths
// with a short quiet interval, then probes the interval boundary.
module cmd_frame_rx_test;
    localparam int G = 4;
    localparam logic [15:0] MASK = 16'hA5C3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] word_in;
    logic        word_valid;
    logic [3:0]  opcode_out;
    logic [11:0] length_out;
    logic [15:0] payload_out;
    logic        payload_valid, frame_done, nack_valid, gap_error, busy;

    int  checks = 0;
    int  errors = 0;
    bit  exp_gerr = 1'b0;
    bit  done_flag = 1'b0;

    cmd_frame_rx #(
        .OPC_W(4), .LEN_W(12), .SUPPORT_MASK(MASK), .GAP_CYCLES(G)
    ) uut (
        .clk(clk), .rst_n(rst_n), .word_in(word_in), .word_valid(word_valid),
        .opcode_out(opcode_out), .length_out(length_out),
        .payload_out(payload_out), .payload_valid(payload_valid),
        .frame_done(frame_done), .nack_valid(nack_valid),
        .gap_error(gap_error), .busy(busy)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    function automatic logic [15:0] pword(input int opc, input int len, input int k);
        return 16'(((opc * 4099) ^ (len * 257) ^ (k * 31) ^ 16'h5A5A));
    endfunction

    // Sends one frame starting at the current negedge; returns at the
    // negedge of cycle T+G, the first cycle a header is legal again.
    task automatic do_frame(input int opc, input int len, input bit bubbles, input bit viol);
        automatic bit sup = MASK[opc];
        automatic int nw = (len <= 1) ? 0 : len - 1;
        word_valid = 1'b1;
        word_in = {opc[3:0], len[11:0]};
        @(negedge clk);
        chk("R1", "opcode", int'(opcode_out), opc);
        chk("R1", "length", int'(length_out), len);
        chk("R5", "nack", int'(nack_valid), int'(!sup));
        chk("R3", "done after header", int'(frame_done), int'(nw == 0));
        chk("R3", "no payload on header", int'(payload_valid), 0);
        chk("R8", "busy after header", int'(busy), 1);
        chk("R7", "flag", int'(gap_error), int'(exp_gerr));
        for (int k = 0; k < nw; k++) begin
            if (bubbles) begin
                word_valid = 1'b0;
                @(negedge clk);
                chk("R9", "bubble payload", int'(payload_valid), 0);
                chk("R9", "bubble done", int'(frame_done), 0);
            end
            word_valid = 1'b1;
            word_in = pword(opc, len, k);
            @(negedge clk);
            chk("R2", "payload strobe", int'(payload_valid), int'(sup));
            if (sup) chk("R2", "payload data", int'(payload_out), int'(pword(opc, len, k)));
            chk("R4", "done position", int'(frame_done), int'(k == nw - 1));
            chk("R5", "nack once", int'(nack_valid), 0);
        end
        word_valid = 1'b0;
        for (int i = 1; i < G; i++) begin
            @(negedge clk);
            chk("R8", "busy in gap", int'(busy), 1);
            chk("R4", "done single", int'(frame_done), 0);
            if (viol && i == G - 1) begin
                word_valid = 1'b1;
                word_in = {4'd0, 12'd3};
            end
        end
        @(negedge clk);
        word_valid = 1'b0;
        chk("R6", "idle at T+G", int'(busy), 0);
        if (viol) begin
            exp_gerr = 1'b1;
            chk("R7", "flag set", int'(gap_error), 1);
            chk("R7", "opcode kept", int'(opcode_out), opc);
            chk("R7", "no payload", int'(payload_valid), 0);
            chk("R7", "no nack", int'(nack_valid), 0);
            chk("R7", "no done", int'(frame_done), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        automatic int lens[5] = '{0, 1, 2, 3, 6};
        rst_n = 1'b0;
        word_valid = 1'b0;
        word_in = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "opcode", int'(opcode_out), 0);
        chk("R10", "length", int'(length_out), 0);
        chk("R10", "payload", int'(payload_out), 0);
        chk("R10", "strobes", int'({payload_valid, frame_done, nack_valid}), 0);
        chk("R10", "flag", int'(gap_error), 0);
        chk("R10", "busy", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8", "idle busy", int'(busy), 0);
        for (int opc = 0; opc < 16; opc++)
            for (int li = 0; li < 5; li++)
                do_frame(opc, lens[li], (opc % 3) == 0, 1'b0);
        do_frame(6, 2, 1'b0, 1'b1);   // R7: intrusion in last forbidden cycle
        do_frame(0, 3, 1'b0, 1'b0);   // R6: accepted at T+G despite flag
        do_frame(7, 3, 1'b1, 1'b0);
        do_frame(9, 5, 1'b0, 1'b0);
        do_frame(0, 40, 1'b0, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10", "flag cleared", int'(gap_error), 0);
        chk("R10", "busy cleared", int'(busy), 0);
        done_flag = 1'b1;
        report();
    end
endmodule